// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory request into a stream of byte addresses, one element per clock. A request is made of a base address, an addressing mode, a stride, and a vector length. The block accepts the request while it is idle. It then offers element addresses on a valid/ready output port until the vector is used up. The final address is marked, and a one-cycle completion pulse follows.

Three access patterns are available. Contiguous access walks memory in steps of one 8-byte element. Strided access steps by a signed element count taken from a scalar operand. Indexed access, for gather and scatter, adds a per-element signed offset to the base. That offset comes from a separate index stream, which has its own valid/ready pair. Every offset is counted in elements and scaled by 8 to give bytes. All address arithmetic wraps modulo 2^32.

Top module: `vec_agu`

## Requirements
- R1: While reset is asserted and after it is released, `addr_valid`, `addr_last`, `busy`, `done` and `idx_ready` are all 0.
- R2: Mode code 0 (contiguous) gives element k the address base + 8·k. Mode code 3 behaves the same as code 0.
- R3: Mode code 1 (strided) gives element k the address base + 8·k·stride, where `cfg_stride` is read as a two's-complement element count.
- R4: Mode code 2 (indexed) gives element k the address base + 8·idx_k, where idx_k is the k-th value accepted on the index stream. `addr_valid` requires `idx_valid`, and `idx_ready` is high only in a cycle where the address is taken.
- R5: A request produces exactly min(`cfg_vlen`, 64) addresses. `addr_elem` numbers them 0, 1, 2, … in order.
- R6: `addr_last` is high on the final element and on no other element.
- R7: In the cycle after the final address is taken, `done` is high for one cycle and `busy` is low.
- R8: A request with length 0 produces no address, and `done` is high in the cycle after the request.
- R9: While `addr_valid` is high and `addr_ready` is low, the offered address and element number stay unchanged in contiguous and strided modes.
- R10: A `start` pulse seen while `busy` is high is ignored, and the running sequence is unaffected.
- R11: Address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when idle |
| cfg_base | input | 32 | Base byte address |
| cfg_mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 as 0 |
| cfg_stride | input | 32 | Signed stride in elements |
| cfg_vlen | input | 7 | Element count, clamped to 64 |
| idx_valid | input | 1 | Index value available |
| idx_data | input | 32 | Signed index in elements |
| idx_ready | output | 1 | Index value consumed |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts address |
| addr_out | output | 32 | Byte address |
| addr_elem | output | 6 | Element number of the offered address |
| addr_last | output | 1 | Offered address is the final one |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are request strobes that arrive mid-sequence, and indexed runs where the index stream and the consumer stall in different cycles. The directed runs drive several `addr_ready` patterns. They drop `idx_valid` on a separate cadence so that the two stalls overlap and separate. During one long run a second request with different settings is fired, and the original address sequence must continue untouched. Strided and base values near the top of the address space push the sums across the 2^32 boundary.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    VM_UNIT   = 2'd0,
    VM_STRIDE = 2'd1,
    VM_INDEX  = 2'd2,
    VM_RSVD   = 2'd3
  } vmode_e;
endpackage

// File: rtl/vagu_ctrl.sv
module vagu_ctrl
  import vagu_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int ELEM_W = $clog2(MAX_VL),
  localparam int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [VL_W-1:0]   cfg_vlen,
  input  logic              fire,
  output logic              load,
  output logic              busy,
  output logic [ELEM_W-1:0] elem,
  output logic              last,
  output logic              done,
  output vmode_e            run_mode
);
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [ELEM_W-1:0] elem_q, elem_d, last_idx_q;
  vmode_e            mode_q;
  logic [VL_W-1:0]   vlen_eff;
  logic              accept, empty, elem_en;

  always_comb begin
    vlen_eff = (cfg_vlen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cfg_vlen;
    accept   = start & ~busy_q;
    empty    = (vlen_eff == '0);
    load     = accept & ~empty;
    last     = busy_q & (elem_q == last_idx_q);
    busy_d   = busy_q;
    if (load)             busy_d = 1'b1;
    else if (fire & last) busy_d = 1'b0;
    done_d   = (accept & empty) | (fire & last);
    elem_en  = load | fire;
    elem_d   = load ? '0 : elem_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
    end else if (elem_en) begin
      elem_q <= elem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx_q <= '0;
      mode_q     <= VM_UNIT;
    end else if (load) begin
      last_idx_q <= ELEM_W'(vlen_eff - 1'b1);
      mode_q     <= vmode_e'(cfg_mode);
    end
  end

  assign busy     = busy_q;
  assign elem     = elem_q;
  assign done     = done_q;
  assign run_mode = mode_q;
endmodule

// File: rtl/vagu_stepper.sv
module vagu_stepper
  import vagu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 8,
  localparam int SHIFT     = $clog2(ELEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              advance,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] step_q, step_d;
  logic [ADDR_W-1:0] off_q, off_d;
  logic              off_en;

  always_comb begin
    if (vmode_e'(cfg_mode) == VM_STRIDE) step_d = cfg_stride << SHIFT;
    else                                 step_d = ADDR_W'(ELEM_BYTES);
    off_en = load | advance;
    off_d  = load ? '0 : off_q + step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (load) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  assign offset = off_q;
endmodule

// File: rtl/vagu_addr.sv
module vagu_addr
  import vagu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 8,
  localparam int SHIFT     = $clog2(ELEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  vmode_e            run_mode,
  input  logic              busy,
  input  logic [ADDR_W-1:0] offset,
  input  logic              idx_valid,
  input  logic [ADDR_W-1:0] idx_data,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic              idx_ready,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] rel;
  logic              use_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= cfg_base;
    end
  end

  always_comb begin
    use_idx    = (run_mode == VM_INDEX);
    rel        = use_idx ? (idx_data << SHIFT) : offset;
    addr_out   = base_q + rel;
    addr_valid = busy & (~use_idx | idx_valid);
    idx_ready  = busy & use_idx & idx_valid & addr_ready;
  end
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import vagu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 8,
  parameter int MAX_VL     = 64,
  localparam int ELEM_W    = $clog2(MAX_VL),
  localparam int VL_W      = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic [VL_W-1:0]   cfg_vlen,
  input  logic              idx_valid,
  input  logic [ADDR_W-1:0] idx_data,
  output logic              idx_ready,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ELEM_W-1:0] addr_elem,
  output logic              addr_last,
  output logic              busy,
  output logic              done
);
  logic              load, fire, last;
  logic [ADDR_W-1:0] offset;
  vmode_e            run_mode;

  assign fire      = addr_valid & addr_ready;
  assign addr_last = last;

  vagu_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_vlen(cfg_vlen), .fire(fire), .load(load), .busy(busy),
    .elem(addr_elem), .last(last), .done(done), .run_mode(run_mode)
  );

  vagu_stepper #(.ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_mode(cfg_mode),
    .cfg_stride(cfg_stride), .advance(fire), .offset(offset)
  );

  vagu_addr #(.ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_base(cfg_base),
    .run_mode(run_mode), .busy(busy), .offset(offset),
    .idx_valid(idx_valid), .idx_data(idx_data), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .idx_ready(idx_ready), .addr_out(addr_out)
  );
endmodule

// File: rtl/vagu_chk.sv
module vagu_chk
  import vagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic [ELEM_W-1:0] addr_elem,
  input logic              addr_last,
  input logic              idx_ready,
  input logic              busy,
  input logic              done,
  input vmode_e            run_mode
);
  // R1
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> busy);
  // R5
  first_elem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> addr_elem == '0);
  // R5
  elem_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && !addr_last |=> addr_elem == $past(addr_elem) + 1'b1);
  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && !addr_last && (run_mode == VM_UNIT)
      |=> addr_out == $past(addr_out) + ADDR_W'(8));
  // R7
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && addr_last |=> done && !busy);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && (run_mode != VM_INDEX)
      |=> addr_valid && $stable(addr_out) && $stable(addr_elem));
  // R4
  idx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> addr_valid && addr_ready && (run_mode == VM_INDEX));
endmodule

bind vec_agu vagu_chk #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr_out(addr_out), .addr_elem(addr_elem), .addr_last(addr_last),
  .idx_ready(idx_ready), .busy(busy), .done(done), .run_mode(run_mode)
);

// File: tb/test_vec_agu.sv
module test_vec_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] cfg_base;
  logic [1:0]  cfg_mode;
  logic [31:0] cfg_stride;
  logic [6:0]  cfg_vlen;
  logic        idx_valid;
  logic [31:0] idx_data;
  logic        idx_ready;
  logic        addr_valid;
  logic        addr_ready;
  logic [31:0] addr_out;
  logic [5:0]  addr_elem;
  logic        addr_last;
  logic        busy;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] idx_tab [64];

  always #5 clk = ~clk;

  vec_agu i_vec_agu (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_mode(cfg_mode), .cfg_stride(cfg_stride), .cfg_vlen(cfg_vlen),
    .idx_valid(idx_valid), .idx_data(idx_data), .idx_ready(idx_ready),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .addr_elem(addr_elem), .addr_last(addr_last), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // One request, checked element by element.
  task automatic run_case(input logic [1:0] m, input logic [31:0] b,
                          input logic [31:0] s, input int vl, input int rpat,
                          input bit poke, input string req);
    int n, k, cyc;
    bit prev_hold;
    logic [31:0] prev_addr, exp;
    bit rdy;
    n = (vl > 64) ? 64 : vl;
    for (int i = 0; i < 64; i++) idx_tab[i] = 32'(i * 13 - 20);
    @(negedge clk);
    start = 1'b1; cfg_mode = m; cfg_base = b; cfg_stride = s; cfg_vlen = 7'(vl);
    k = 0; cyc = 0; prev_hold = 0; prev_addr = '0;
    while (k < n && cyc < 2000) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1; cfg_mode = 2'd1; cfg_base = 32'h1234_0000;
        cfg_stride = 32'd5; cfg_vlen = 7'd3;
      end
      case (rpat)
        1:       rdy = (cyc % 4) != 2;
        2:       rdy = (cyc % 2) == 1;
        default: rdy = 1'b1;
      endcase
      addr_ready = rdy;
      idx_valid  = (m == 2'd2) ? ((cyc % 3) != 1) : 1'b0;
      idx_data   = idx_tab[k];
      #1;
      if (prev_hold && m != 2'd2) chk(addr_out == prev_addr, "R9 hold", addr_out, prev_addr);
      if (addr_valid && addr_ready) begin
        case (m)
          2'd1:    exp = b + 32'(k) * (s << 3);
          2'd2:    exp = b + (idx_tab[k] << 3);
          default: exp = b + 32'(k * 8);
        endcase
        chk(addr_out == exp, req, addr_out, exp);
        chk(addr_elem == 6'(k), "R5 elem", 32'(addr_elem), 32'(k));
        chk(addr_last == (k == n - 1), "R6 last", 32'(addr_last), 32'(k == n - 1));
        if (m == 2'd2) chk(idx_ready == 1'b1, "R4 pop", 32'(idx_ready), 32'd1);
        k++;
        prev_hold = 0;
      end else begin
        if (m == 2'd2) chk(idx_ready == 1'b0, "R4 nopop", 32'(idx_ready), 32'd0);
        prev_hold = addr_valid;
      end
      prev_addr = addr_out;
      cyc++;
    end
    chk(cyc < 2000, "R5 count", 32'(k), 32'(n));
    @(negedge clk);
    start = 1'b0; addr_ready = 1'b0; idx_valid = 1'b0;
    #1;
    chk(done == 1'b1, (n == 0) ? "R8 done" : "R7 done", 32'(done), 32'd1);
    chk(busy == 1'b0 && addr_valid == 1'b0, "R7 idle", {busy, addr_valid}, 32'd0);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R7 pulse", 32'(done), 32'd0);
    chk(addr_valid == 1'b0, "R5 no extra", 32'(addr_valid), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; cfg_base = '0; cfg_mode = '0; cfg_stride = '0;
    cfg_vlen = '0; idx_valid = 1'b0; idx_data = '0; addr_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk({addr_valid, addr_last, busy, done, idx_ready} == 5'b0, "R1 in reset",
        32'({addr_valid, addr_last, busy, done, idx_ready}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({addr_valid, addr_last, busy, done, idx_ready} == 5'b0, "R1 after reset",
        32'({addr_valid, addr_last, busy, done, idx_ready}), 32'd0);
  endtask

  task automatic t_unit();      run_case(2'd0, 32'h0000_1000, 32'd0, 64, 0, 0, "R2 unit full");       endtask
  task automatic t_unit_rsvd(); run_case(2'd3, 32'h0000_2000, 32'd7, 9, 1, 0, "R2 code3");            endtask
  task automatic t_stride();    run_case(2'd1, 32'h0001_0000, 32'd3, 20, 1, 0, "R3 stride");          endtask
  task automatic t_stride_neg();run_case(2'd1, 32'h0000_0100, 32'hFFFF_FFFE, 17, 2, 0, "R11 neg wrap"); endtask
  task automatic t_index();     run_case(2'd2, 32'h0004_0000, 32'd0, 30, 1, 0, "R4 index");           endtask
  task automatic t_index_wrap();run_case(2'd2, 32'h0000_0040, 32'd0, 12, 2, 0, "R11 idx wrap");       endtask
  task automatic t_zero();      run_case(2'd0, 32'h0000_3000, 32'd0, 0, 0, 0, "R8 zero");             endtask
  task automatic t_clamp();     run_case(2'd0, 32'hFFFF_FF00, 32'd0, 100, 1, 0, "R5 clamp");          endtask
  task automatic t_one();       run_case(2'd1, 32'h0000_0800, 32'd9, 1, 2, 0, "R6 single");           endtask
  task automatic t_poke();      run_case(2'd0, 32'h0002_0000, 32'd0, 16, 1, 1, "R10 busy start");     endtask

  initial begin
    t_reset();
    t_unit();
    t_unit_rsvd();
    t_stride();
    t_stride_neg();
    t_index();
    t_index_wrap();
    t_zero();
    t_clamp();
    t_one();
    t_poke();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 32'd0, 32'd1);
    finish_run();
  end
endmodule